// File: doc/BRIEF.md
# Linked Descriptor List Walker

This block follows a chain of transfer descriptors kept in memory, on behalf of a single channel. Each descriptor is three consecutive memory words: the buffer address, the transfer length in bytes, and a link word. The link word holds the address of the following descriptor. Its two lowest bits carry control flags: bit 0 gives the direction (1 means the board writes to host memory, 0 means host memory feeds the board), and bit 1 marks the descriptor as the final one. Those two bits are cleared to zero to get the real address of the next descriptor.

The host starts a walk by pulsing `start_valid` with the address of the first descriptor. The walker then reads words one at a time over a memory request/response port. After each complete descriptor it offers one job (address, length, direction) to a data mover over a valid/ready handshake. It then waits for the mover's `xfer_done` pulse before it fetches anything further. Descriptors of length zero are passed over without a job. A read error ends the walk at once and raises a sticky error flag.

Back-pressure rules:
- **Memory requests:** while `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` does not change.
- **Jobs:** while `job_ready` is low, `job_valid` stays high and all job fields stay unchanged.
- **Responses:** `mem_rsp_valid` has no ready signal. The walker has at most one read in flight and always takes the response.

Top module: `dma_chain_walker`

## Requirements
- R1: While idle, a `start_valid` pulse loads `start_ptr` with bits [1:0] cleared. The walker then reads byte addresses ptr, ptr+4 and ptr+8 in that order, each request issued only after the previous response. A `start_valid` while `busy` is high is ignored. A memory request and a job are never offered in the same cycle.
- R2: Once `mem_req_valid` is high, it and `mem_req_addr` hold steady until a cycle with `mem_req_ready` high.
- R3: The job carries `job_addr` = word 0, `job_len` = word 1 bits [15:0], and `job_to_host` = bit 0 of word 2 (1 = board to host).
- R4: Once `job_valid` is high, it and all job fields hold steady until a cycle with `job_ready` high.
- R5: The next descriptor address is word 2 with bits [1:0] cleared. Its first read is requested only after `xfer_done` has arrived for the current job. A `xfer_done` with no job in progress is ignored.
- R6: When bit 1 of word 2 is set, no further read follows. `done` pulses high for exactly one cycle, with `busy` already low, once that descriptor is finished. While idle, no request and no job are offered.
- R7: A descriptor whose length field is zero produces no job. The walk then moves on to its link, or finishes with `done` if it is the last descriptor.
- R8: A response with `mem_rsp_err` high ends the walk. `busy` drops, no job or `done` follows, and `err` is set. `err` stays high until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start pulse from host |
| start_ptr | input | 32 | Byte address of first descriptor |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when a walk ends normally |
| err | output | 1 | Sticky read-error flag |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Byte address to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Read failed |
| job_valid | output | 1 | Job offered to data mover |
| job_ready | input | 1 | Data mover accepts job |
| job_addr | output | 32 | Buffer address |
| job_len | output | 16 | Length in bytes (never zero) |
| job_to_host | output | 1 | 1 = board to host, 0 = host to board |
| xfer_done | input | 1 | Data mover finished the accepted job |

## Verification
The assertions check every cycle for the following:
- Requests and jobs stay stable under back-pressure.
- Request addresses are word aligned.
- A request and a job are never offered together.
- Zero-length jobs never appear.
- Nothing is offered while idle, and `done` occurs only while idle.
- The error flag stays set.

Only the bench's scenarios can show the rest: the walker follows the correct chain, fields are taken from the right words, fetching pauses until `xfer_done`, zero-length descriptors are skipped, a start during a walk is ignored, and an error ends a walk cleanly. The bench shows these by comparing the job stream and the fetch address log with a model that walks the memory image.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  localparam int FLAG_BITS = 2;
  localparam int FLAG_DIR  = 0;
  localparam int FLAG_LAST = 1;
  localparam int WORDS_PER_DESC = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_EVAL,
    ST_JOB,
    ST_XFER
  } walk_state_e;
endpackage

// File: rtl/dcw_link_decode.sv
module dcw_link_decode #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] link_word,
  output logic [AW-1:0] next_ptr,
  output logic          to_host,
  output logic          is_last
);
  import dcw_pkg::*;
  localparam logic [AW-1:0] FLAG_MASK = AW'((1 << FLAG_BITS) - 1);

  always_comb begin
    next_ptr = link_word & ~FLAG_MASK;
    to_host  = link_word[FLAG_DIR];
    is_last  = link_word[FLAG_LAST];
  end
endmodule

// File: rtl/dcw_desc_regs.sv
module dcw_desc_regs #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [1:0]    cap_idx,
  input  logic [DW-1:0] cap_data,
  output logic [AW-1:0] buf_addr,
  output logic [LEN_W-1:0] buf_len,
  output logic [AW-1:0] link_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_addr  <= '0;
      buf_len   <= '0;
      link_word <= '0;
    end else if (cap_en) begin
      case (cap_idx)
        2'd0:    buf_addr  <= cap_data[AW-1:0];
        2'd1:    buf_len   <= cap_data[LEN_W-1:0];
        default: link_word <= cap_data[AW-1:0];
      endcase
    end
  end
endmodule

// File: rtl/dcw_job_port.sv
module dcw_job_port #(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    in_addr,
  input  logic [LEN_W-1:0] in_len,
  input  logic             in_to_host,
  output logic             job_valid,
  input  logic             job_ready,
  output logic [AW-1:0]    job_addr,
  output logic [LEN_W-1:0] job_len,
  output logic             job_to_host,
  output logic             accepted
);
  assign accepted = job_valid && job_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      job_valid   <= 1'b0;
      job_addr    <= '0;
      job_len     <= '0;
      job_to_host <= 1'b0;
    end else if (load) begin
      job_valid   <= 1'b1;
      job_addr    <= in_addr;
      job_len     <= in_len;
      job_to_host <= in_to_host;
    end else if (accepted) begin
      job_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
  import dcw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  input  logic [AW-1:0]    start_ptr,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  input  logic             mem_rsp_err,
  output logic             job_valid,
  input  logic             job_ready,
  output logic [AW-1:0]    job_addr,
  output logic [LEN_W-1:0] job_len,
  output logic             job_to_host,
  input  logic             xfer_done
);
  localparam int WB_SHIFT = $clog2(DW / 8);
  localparam logic [AW-1:0] FLAG_MASK = AW'((1 << FLAG_BITS) - 1);
  localparam logic [1:0] LAST_IDX = 2'(WORDS_PER_DESC - 1);

  walk_state_e st;
  logic [AW-1:0]    cur_ptr;
  logic [1:0]       widx;
  logic [AW-1:0]    d_addr;
  logic [LEN_W-1:0] d_len;
  logic [AW-1:0]    d_link;
  logic [AW-1:0]    next_ptr;
  logic             d_to_host;
  logic             d_last;
  logic             cap_en;
  logic             job_load;
  logic             job_acc;
  logic             done_q;
  logic             err_q;

  assign cap_en        = (st == ST_WAIT) && mem_rsp_valid && !mem_rsp_err;
  assign job_load      = (st == ST_EVAL) && (d_len != '0);
  assign mem_req_valid = (st == ST_REQ);
  assign mem_req_addr  = cur_ptr + (AW'(widx) << WB_SHIFT);
  assign busy          = (st != ST_IDLE);
  assign done          = done_q;
  assign err           = err_q;

  dcw_desc_regs #(.DW(DW), .AW(AW), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(widx),
    .cap_data(mem_rsp_data), .buf_addr(d_addr), .buf_len(d_len),
    .link_word(d_link)
  );

  dcw_link_decode #(.AW(AW)) u_link (
    .link_word(d_link), .next_ptr(next_ptr),
    .to_host(d_to_host), .is_last(d_last)
  );

  dcw_job_port #(.AW(AW), .LEN_W(LEN_W)) u_job (
    .clk(clk), .rst_n(rst_n), .load(job_load), .in_addr(d_addr),
    .in_len(d_len), .in_to_host(d_to_host), .job_valid(job_valid),
    .job_ready(job_ready), .job_addr(job_addr), .job_len(job_len),
    .job_to_host(job_to_host), .accepted(job_acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cur_ptr <= '0;
      widx    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_valid) begin
            cur_ptr <= start_ptr & ~FLAG_MASK;
            widx    <= '0;
            err_q   <= 1'b0;
            st      <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              err_q <= 1'b1;
              st    <= ST_IDLE;
            end else if (widx == LAST_IDX) begin
              st <= ST_EVAL;
            end else begin
              widx <= widx + 2'd1;
              st   <= ST_REQ;
            end
          end
        end
        ST_EVAL: begin
          if (d_len != '0) begin
            st <= ST_JOB;
          end else if (d_last) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            cur_ptr <= next_ptr;
            widx    <= '0;
            st      <= ST_REQ;
          end
        end
        ST_JOB: begin
          if (job_acc) st <= ST_XFER;
        end
        ST_XFER: begin
          if (xfer_done) begin
            if (d_last) begin
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              cur_ptr <= next_ptr;
              widx    <= '0;
              st      <= ST_REQ;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcw_checker.sv
module dcw_checker #(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_valid,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_req_addr,
  input logic             job_valid,
  input logic             job_ready,
  input logic [AW-1:0]    job_addr,
  input logic [LEN_W-1:0] job_len,
  input logic             job_to_host
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R2
  AST_REQ_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00); // R5
  AST_JOB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && !job_ready |=> job_valid && $stable(job_addr) && $stable(job_len) && $stable(job_to_host)); // R4
  AST_NO_ZERO_JOB: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid |-> job_len != '0); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && job_valid)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !job_valid); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start_valid |=> err); // R8
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !done); // R8
endmodule

bind dma_chain_walker dcw_checker #(.AW(AW), .LEN_W(LEN_W)) u_dcw_checker (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .busy(busy),
  .done(done), .err(err), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .job_valid(job_valid), .job_ready(job_ready), .job_addr(job_addr),
  .job_len(job_len), .job_to_host(job_to_host)
);

// File: tb/test_dma_chain_walker.sv
module test_dma_chain_walker;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic [31:0] start_ptr = '0;
  logic busy, done, err;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic mem_rsp_err = 1'b0;
  logic job_valid, job_ready = 1'b0;
  logic [31:0] job_addr;
  logic [15:0] job_len;
  logic job_to_host;
  logic xfer_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_walker i_dma_chain_walker (.*);

  int n_checks = 0, n_fails = 0;
  logic [31:0] mem [64];
  bit          err_w [64];
  logic [31:0] exp_fetch [128];
  logic [31:0] exp_jaddr [32];
  logic [15:0] exp_jlen [32];
  bit          exp_jdir [32];
  int exp_fn, exp_jn;
  bit exp_err;
  logic [31:0] fetch_log [128];
  int fetch_n = 0, job_idx = 0, done_cnt = 0;
  int acc_cnt = 0, mv_cnt = 0;
  logic [31:0] acc_addr = '0;
  bit prev_req_stall = 0, prev_job_stall = 0;
  logic [31:0] prev_req_addr, prev_jaddr;
  logic [15:0] prev_jlen;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Model walk over memory image
  function automatic void model_walk(input logic [31:0] first);
    logic [31:0] p, w0, w1, w2;
    exp_fn = 0; exp_jn = 0; exp_err = 0;
    p = first & ~32'h3;
    for (int d = 0; d < 40; d++) begin
      for (int w = 0; w < 3; w++) begin
        exp_fetch[exp_fn] = p + 32'(4*w);
        exp_fn++;
        if (err_w[(p >> 2) + w]) begin exp_err = 1; return; end
      end
      w0 = mem[p >> 2]; w1 = mem[(p >> 2) + 1]; w2 = mem[(p >> 2) + 2];
      if (w1[15:0] != 16'h0) begin
        exp_jaddr[exp_jn] = w0; exp_jlen[exp_jn] = w1[15:0]; exp_jdir[exp_jn] = w2[0];
        exp_jn++;
      end
      if (w2[1]) return;
      p = w2 & ~32'h3;
    end
  endfunction

  // Memory and data-mover models: drive at negedge
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; xfer_done = 1'b0;
    if (acc_cnt == 1) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem[acc_addr[7:2]];
      mem_rsp_err   = err_w[acc_addr[7:2]];
    end
    if (mv_cnt == 1) xfer_done = 1'b1;
    mem_req_ready = ($urandom % 4) != 0;
    job_ready     = ($urandom % 3) != 0;
  end

  // Monitor: sample handshakes at posedge
  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_req_stall) check(mem_req_valid && mem_req_addr == prev_req_addr, "R2 request held", mem_req_addr, prev_req_addr);
      if (prev_job_stall) check(job_valid && job_addr == prev_jaddr && job_len == prev_jlen, "R4 job held", job_addr, prev_jaddr);
      prev_req_stall = mem_req_valid && !mem_req_ready; prev_req_addr = mem_req_addr;
      prev_job_stall = job_valid && !job_ready; prev_jaddr = job_addr; prev_jlen = job_len;
      if (mem_req_valid && mem_req_ready) begin
        check(mv_cnt == 0, "R5 fetch before xfer_done", 32'(mv_cnt), 0);
        if (fetch_n < 128) fetch_log[fetch_n] = mem_req_addr;
        fetch_n++;
        acc_addr = mem_req_addr; acc_cnt = 1 + int'($urandom % 3);
      end else if (acc_cnt != 0) acc_cnt--;
      if (job_valid && job_ready) begin
        if (job_idx < exp_jn)
          check(job_addr == exp_jaddr[job_idx] && job_len == exp_jlen[job_idx] && job_to_host == exp_jdir[job_idx],
                "R3 job fields", job_addr ^ 32'(job_len), exp_jaddr[job_idx] ^ 32'(exp_jlen[job_idx]));
        else check(0, "R7 unexpected job", 32'(job_idx), 32'(exp_jn));
        job_idx++;
        mv_cnt = 1 + int'($urandom % 4);
      end else if (mv_cnt != 0) mv_cnt--;
      if (done) done_cnt++;
    end
  end

  // Place a chain of n descriptors; zero_sel picks a length-zero descriptor (-1 none)
  task automatic build_chain(input int n, input int first_slot, input int zero_sel, output logic [31:0] head);
    int s, ns;
    for (int i = 0; i < 64; i++) begin mem[i] = $urandom; err_w[i] = 0; end
    for (int i = 0; i < n; i++) begin
      s  = (first_slot + 5*i) % NSLOT;
      ns = (first_slot + 5*(i+1)) % NSLOT;
      mem[3*s]   = $urandom;
      mem[3*s+1] = {16'($urandom), 16'(1 + $urandom % 16'hfffe)};
      if (i == zero_sel || (zero_sel == -2 && ($urandom % 5) == 0)) mem[3*s+1][15:0] = 16'h0;
      mem[3*s+2] = 32'(12*ns) | 32'($urandom % 2) | ((i == n-1) ? 32'h2 : 32'h0);
    end
    head = 32'(12 * first_slot);
  endtask

  task automatic run_walk(input logic [31:0] head, input bit stray, input string tag);
    int t;
    fetch_n = 0; job_idx = 0; done_cnt = 0;
    model_walk(head);
    @(negedge clk); start_valid = 1'b1; start_ptr = head | 32'($urandom % 4);
    @(negedge clk); start_valid = 1'b0;
    if (stray) begin
      repeat (3) @(negedge clk);
      start_valid = 1'b1; start_ptr = head + 32'd12;
      @(negedge clk); start_valid = 1'b0;
    end
    t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    check(t < 5000, {tag, " walk ended"}, 32'(t), 0);
    repeat (2) @(negedge clk);
    check(err == exp_err, {tag, " R8 err flag"}, 32'(err), 32'(exp_err));
    check(done_cnt == (exp_err ? 0 : 1), {tag, " R6 done pulses"}, 32'(done_cnt), 32'(!exp_err));
    check(job_idx == exp_jn, {tag, " R7 job count"}, 32'(job_idx), 32'(exp_jn));
    check(fetch_n == exp_fn, {tag, " R1 R5 fetch count"}, 32'(fetch_n), 32'(exp_fn));
    for (int i = 0; i < exp_fn && i < fetch_n && i < 128; i++)
      if (fetch_log[i] != exp_fetch[i]) begin
        check(0, {tag, " R1 R5 fetch address"}, fetch_log[i], exp_fetch[i]);
        break;
      end
  endtask

  initial begin
    logic [31:0] head;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) begin mem[i] = '0; err_w[i] = 0; end
    exp_jn = 0;
    repeat (4) @(negedge clk);
    check(!busy && !done && !err && !mem_req_valid && !job_valid, "R6 reset state",
          {27'b0, busy, done, err, mem_req_valid, job_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: single descriptor
    build_chain(1, 4, -1, head); run_walk(head, 0, "single");
    // directed: zero-length in the middle
    build_chain(4, 2, 1, head); run_walk(head, 0, "R7 zero middle");
    // directed: zero-length last descriptor
    build_chain(3, 7, 2, head); run_walk(head, 0, "R7 zero last");
    // directed: start pulse during walk ignored
    build_chain(3, 1, -1, head); run_walk(head, 1, "R1 stray start");
    // directed: read error on second descriptor length word
    build_chain(4, 3, -1, head);
    err_w[3*((3 + 5) % NSLOT) + 1] = 1;
    run_walk(head, 0, "R8 error abort");
    check(err == 1'b1, "R8 err stays set while idle", 32'(err), 1);
    // error flag cleared by next start
    build_chain(2, 9, -1, head); run_walk(head, 0, "R8 clear");
    // random chains
    for (int k = 0; k < 20; k++) begin
      build_chain(1 + int'($urandom % 8), int'($urandom % NSLOT), -2, head);
      run_walk(head, 0, "random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule